// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the effective memory address for single-word and single-byte load and store instructions of a 32-bit core with a conditional, barrel-shifted addressing scheme. It takes the 32-bit instruction word together with the base register value, the offset register value, the data register value and the current carry flag. It returns the address to present to memory, the access size and direction, the base-register writeback request with the value to write back, a flag that marks an unprivileged access, and the data to store.

The offset is either a 12-bit unsigned constant or a register value passed through a shifter whose amount comes from the instruction itself. The offset is added to or subtracted from the base. In pre-indexed form the modified base is the address. In post-indexed form the unmodified base is the address and the base is always written back. In post-indexed form the writeback bit has a different job: it marks the access as unprivileged. The result is registered. An input strobe launches one computation and the outputs keep their values until the next strobe.

Top module: `ls_addr_gen`

## Requirements
- R1: When instruction bit 25 is 0, the offset is the zero-extended 12-bit constant in instruction bits 11:0.
- R2: When instruction bit 25 is 1, the offset is the offset register value shifted by the type in bits 6:5 (00 shift left, 01 logical shift right, 10 arithmetic shift right, 11 rotate right) by the 5-bit amount in bits 11:7.
- R3: A shift amount of 0 with type 01 yields 0. With type 10 it yields 32 copies of the operand's bit 31. With type 11 it yields the operand rotated right by one through carry: carry enters bit 31 and operand bits 31:1 fill bits 30:0.
- R4: Instruction bit 23 set adds the offset to the base. Bit 23 clear subtracts the offset from the base, modulo 2^32.
- R5: With bit 24 set (pre-index) the address is base±offset. With bit 24 clear (post-index) the address is the unmodified base.
- R6: The writeback enable is set when bit 21 is 1 or bit 24 is 0. The writeback value is always base±offset.
- R7: The unprivileged flag is set exactly when bit 24 is 0 and bit 21 is 1.
- R8: The byte-access output equals bit 22 and the load output equals bit 20 (1 = load, 0 = store). The base index output is bits 19:16 and the data index output is bits 15:12.
- R9: For a store, the store data is the data register value, or that value plus 4 when the data index is 15. For a load, the store data is 0.
- R10: Results appear one clock after a cycle with the input strobe high, and the valid output follows the strobe with that one-cycle delay. Without a strobe all result outputs hold. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Launch a computation from the current inputs |
| instr | input | 32 | Load/store instruction word |
| base_val | input | 32 | Base register value |
| ofs_val | input | 32 | Offset register value |
| data_val | input | 32 | Data register value (PC read value when index is 15) |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Results are from the previous strobe |
| mem_addr | output | 32 | Effective memory address |
| byte_acc | output | 1 | 1 = byte access, 0 = word access |
| is_load | output | 1 | 1 = load, 0 = store |
| base_idx | output | 4 | Base register index |
| data_idx | output | 4 | Data register index |
| wb_en | output | 1 | Base register writeback request |
| wb_val | output | 32 | Value to write back to the base register |
| unpriv | output | 1 | Access uses unprivileged translation |
| store_data | output | 32 | Data to be written to memory |

## Verification
The assertions check these properties on every cycle: the valid output trails the strobe by one cycle; results hold when no strobe is given; the unprivileged flag implies a writeback; a pre-indexed address matches the writeback value; a post-indexed address equals the previous base; the immediate-offset sum or difference is correct; and the size and direction bits follow the instruction. Only the bench's vectors can show that the register shifter gives the right values for each type, including the zero-amount cases of the three right shifts. The same holds for the store-data adjustment when the data index is 15 and for the cleared state after reset.

// File: rtl/ls_addr_gen.sv
module ls_addr_gen #(
  parameter int W         = 32,
  parameter int IDX_W     = 4,
  parameter int PC_IDX    = 15,
  parameter int PC_ADJUST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      instr,
  input  logic [W-1:0]     base_val,
  input  logic [W-1:0]     ofs_val,
  input  logic [W-1:0]     data_val,
  input  logic             carry_in,
  output logic             out_valid,
  output logic [W-1:0]     mem_addr,
  output logic             byte_acc,
  output logic             is_load,
  output logic [IDX_W-1:0] base_idx,
  output logic [IDX_W-1:0] data_idx,
  output logic             wb_en,
  output logic [W-1:0]     wb_val,
  output logic             unpriv,
  output logic [W-1:0]     store_data
);

  localparam int SH_W = $clog2(W);

  wire reg_ofs   = instr[25];
  wire pre_idx   = instr[24];
  wire up        = instr[23];
  wire wbit      = instr[21];
  wire ld        = instr[20];
  wire [IDX_W-1:0] rd_sel = instr[15:12];

  wire [SH_W-1:0] amt  = instr[11:7];
  wire [1:0]      kind = instr[6:5];

  logic [W-1:0] shifted;
  logic signed [W-1:0] ofs_s;
  assign ofs_s = ofs_val;

  always_comb begin
    unique case (kind)
      2'b00: shifted = ofs_val << amt;
      2'b01: shifted = (amt == '0) ? '0 : (ofs_val >> amt);
      2'b10: shifted = (amt == '0) ? {W{ofs_val[W-1]}} : W'(ofs_s >>> amt);
      default: shifted = (amt == '0) ? {carry_in, ofs_val[W-1:1]}
                                     : ((ofs_val >> amt) | (ofs_val << (SH_W+1)'(W - int'(amt))));
    endcase
  end

  wire [W-1:0] offset  = reg_ofs ? shifted : W'(instr[11:0]);
  wire [W-1:0] moved   = up ? (base_val + offset) : (base_val - offset);
  wire [W-1:0] st_data = ld ? '0 :
                         (rd_sel == IDX_W'(PC_IDX)) ? data_val + W'(PC_ADJUST) : data_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      mem_addr   <= '0;
      byte_acc   <= 1'b0;
      is_load    <= 1'b0;
      base_idx   <= '0;
      data_idx   <= '0;
      wb_en      <= 1'b0;
      wb_val     <= '0;
      unpriv     <= 1'b0;
      store_data <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        mem_addr   <= pre_idx ? moved : base_val;
        byte_acc   <= instr[22];
        is_load    <= ld;
        base_idx   <= instr[19:16];
        data_idx   <= rd_sel;
        wb_en      <= wbit | ~pre_idx;
        wb_val     <= moved;
        unpriv     <= wbit & ~pre_idx;
        store_data <= st_data;
      end
    end
  end

endmodule

// File: rtl/ls_addr_gen_chk.sv
module ls_addr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] instr,
  input logic [31:0] base_val,
  input logic        out_valid,
  input logic [31:0] mem_addr,
  input logic        byte_acc,
  input logic        is_load,
  input logic        wb_en,
  input logic [31:0] wb_val,
  input logic        unpriv
);

  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  assert_valid_delay_R10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    out_valid == $past(in_valid));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(in_valid) |-> ($stable(mem_addr) && $stable(wb_val) && $stable(wb_en)));

  assert_unpriv_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unpriv |-> wb_en);

  assert_pre_addr_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (out_valid && $past(instr[24])) |-> mem_addr == wb_val);

  assert_post_addr_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (out_valid && !$past(instr[24])) |-> (mem_addr == $past(base_val) && wb_en));

  assert_imm_up_R1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (out_valid && !$past(instr[25]) && $past(instr[23]))
      |-> wb_val == $past(base_val) + {20'b0, $past(instr[11:0])});

  assert_imm_down_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (out_valid && !$past(instr[25]) && !$past(instr[23]))
      |-> wb_val == $past(base_val) - {20'b0, $past(instr[11:0])});

  assert_size_dir_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    out_valid |-> (byte_acc == $past(instr[22]) && is_load == $past(instr[20])));

endmodule

bind ls_addr_gen ls_addr_gen_chk u_chk (.*);

// File: tb/sim_ls_addr_gen.sv
module sim_ls_addr_gen;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic [31:0] instr = 0, base_val = 0, ofs_val = 0, data_val = 0;
  logic carry_in = 0;
  logic out_valid, byte_acc, is_load, wb_en, unpriv;
  logic [31:0] mem_addr, wb_val, store_data;
  logic [3:0] base_idx, data_idx;

  always #2 clk = ~clk;

  ls_addr_gen u0 (.*);

  int n_chk = 0, n_bad = 0;

  function automatic logic [31:0] mk(bit i, bit p, bit u, bit b, bit w, bit l,
                                     logic [3:0] rn, logic [3:0] rd, logic [11:0] off);
    return {4'hE, 2'b01, i, p, u, b, w, l, rn, rd, off};
  endfunction

  typedef struct packed {
    logic [31:0] ins, bas, ofs, dat;
    logic        cin;
    logic [31:0] addr;
    logic        wbe;
    logic [31:0] wbv;
    logic        unp;
    logic [31:0] sd;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    // R1 R4 pre-index add, immediate
    '{mk(0,1,1,0,0,1,4'd1,4'd2,12'h010), 32'h1000, 0, 0, 0, 32'h1010, 0, 32'h1010, 0, 0},
    // R4 R6 pre-index subtract, writeback, byte store
    '{mk(0,1,0,1,1,0,4'd1,4'd3,12'hFFF), 32'h1000, 0, 32'hAABBCCDD, 0, 32'h1, 1, 32'h1, 0, 32'hAABBCCDD},
    // R5 R6 post-index
    '{mk(0,0,1,0,0,1,4'd6,4'd2,12'h004), 32'h2000, 0, 0, 0, 32'h2000, 1, 32'h2004, 0, 0},
    // R7 post-index with W
    '{mk(0,0,1,0,1,1,4'd7,4'd8,12'h008), 32'h3000, 0, 0, 0, 32'h3000, 1, 32'h3008, 1, 0},
    // R2 LSL #2
    '{mk(1,1,1,0,0,1,4'd1,4'd2,12'h105), 32'h100, 32'h3, 0, 0, 32'h10C, 0, 32'h10C, 0, 0},
    // R2 LSR #4
    '{mk(1,1,1,0,0,1,4'd1,4'd2,12'h225), 32'h10, 32'h80000000, 0, 0, 32'h08000010, 0, 32'h08000010, 0, 0},
    // R2 ASR #4
    '{mk(1,1,1,0,0,1,4'd1,4'd2,12'h245), 32'h0, 32'h80000000, 0, 0, 32'hF8000000, 0, 32'hF8000000, 0, 0},
    // R2 ROR #8
    '{mk(1,1,1,0,0,1,4'd1,4'd2,12'h465), 32'h1, 32'hAB, 0, 0, 32'hAB000001, 0, 32'hAB000001, 0, 0},
    // R3 LSR #0 means 32
    '{mk(1,1,1,0,0,1,4'd1,4'd2,12'h025), 32'h500, 32'hFFFFFFFF, 0, 0, 32'h500, 0, 32'h500, 0, 0},
    // R3 ASR #0 negative, subtract
    '{mk(1,1,0,0,0,1,4'd1,4'd2,12'h045), 32'h500, 32'hFFFFFFFF, 0, 0, 32'h501, 0, 32'h501, 0, 0},
    // R3 rotate through carry, carry 1
    '{mk(1,1,1,0,0,1,4'd1,4'd2,12'h065), 32'h0, 32'h2, 0, 1, 32'h80000001, 0, 32'h80000001, 0, 0},
    // R3 rotate through carry, carry 0
    '{mk(1,1,1,0,0,1,4'd1,4'd2,12'h065), 32'h10, 32'h3, 0, 0, 32'h11, 0, 32'h11, 0, 0},
    // R9 store of index 15
    '{mk(0,1,1,0,0,0,4'd1,4'd15,12'h000), 32'h40, 0, 32'h8008, 0, 32'h40, 0, 32'h40, 0, 32'h800C},
    // R9 load of index 15
    '{mk(0,1,1,0,0,1,4'd1,4'd15,12'h000), 32'h40, 0, 32'h8008, 0, 32'h40, 0, 32'h40, 0, 32'h0}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset out_valid", {31'b0, out_valid}, 0);
    chk("R10 reset mem_addr", mem_addr, 0);
    chk("R10 reset wb_val", wb_val, 0);
    chk("R10 reset flags", {28'b0, wb_en, unpriv, byte_acc, is_load}, 0);
    chk("R10 reset store_data", store_data, 0);
    rst_n = 1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      instr = VEC[k].ins; base_val = VEC[k].bas; ofs_val = VEC[k].ofs;
      data_val = VEC[k].dat; carry_in = VEC[k].cin; in_valid = 1;
      @(negedge clk);
      in_valid = 0;
      chk($sformatf("R10 v%0d out_valid", k), {31'b0, out_valid}, 1);
      chk($sformatf("R5 R2 v%0d mem_addr", k), mem_addr, VEC[k].addr);
      chk($sformatf("R6 v%0d wb_en", k), {31'b0, wb_en}, {31'b0, VEC[k].wbe});
      chk($sformatf("R6 R4 v%0d wb_val", k), wb_val, VEC[k].wbv);
      chk($sformatf("R7 v%0d unpriv", k), {31'b0, unpriv}, {31'b0, VEC[k].unp});
      chk($sformatf("R9 v%0d store_data", k), store_data, VEC[k].sd);
      chk($sformatf("R8 v%0d byte/load", k), {30'b0, byte_acc, is_load},
          {30'b0, VEC[k].ins[22], VEC[k].ins[20]});
      chk($sformatf("R8 v%0d indices", k), {24'b0, base_idx, data_idx},
          {24'b0, VEC[k].ins[19:16], VEC[k].ins[15:12]});
    end

    // R10 hold without strobe
    instr = mk(0,1,1,0,1,1,4'd9,4'd9,12'h123); base_val = 32'h7777; in_valid = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 hold out_valid", {31'b0, out_valid}, 0);
    chk("R10 hold mem_addr", mem_addr, VEC[NV-1].addr);
    chk("R10 hold base_idx", {28'b0, base_idx}, 32'd1);

    // R3 ASR #0 on a positive value gives zero
    instr = mk(1,1,1,0,0,1,4'd1,4'd2,12'h045); base_val = 32'h20; ofs_val = 32'h7FFFFFFF;
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R3 asr0 positive mem_addr", mem_addr, 32'h20);

    // R10 reset clears after activity
    rst_n = 0;
    @(negedge clk);
    chk("R10 re-reset mem_addr", mem_addr, 0);
    chk("R10 re-reset out_valid", {31'b0, out_valid}, 0);
    finish_run();
  end

endmodule